// File: doc/BRIEF.md
# Four-Tap Transmit FIR Equalizer

This block is the digital core of a serial transmitter's feed-forward equalizer. Each valid cycle it takes one NRZ bit and produces one signed amplitude code for the line driver. The code is a weighted sum of four neighbouring bits: one pre-cursor, the main cursor and two post-cursors. Before weighting, each bit is mapped to +1 or -1. Each of the four weights is a programmable signed coefficient. The weights emphasise transitions and attenuate long runs, which compensates for the low-pass loss of the channel.

The coefficient set is written as one word and takes effect only on a load strobe. The block checks every candidate set before it accepts it. The magnitudes of the four weights must add up to exactly the full-scale value, so the total drive stays constant. The pre-cursor and first post-cursor weights must not be positive. A set that breaks either rule is rejected and flagged, and the previous legal set stays in use. After reset the equalizer passes data straight through: the main cursor is at full scale and the other weights are zero. Gaps in the input stream are allowed, and the bit history moves only on valid bits.

Top module: `tx_fir_eq`

## Requirements
- R1: After reset, out_valid is 0, out_code is 0 and cfg_error is 0. The three stored history bits all read as 0, which maps to -1.
- R2: After reset the active weights are pre 0, main +63, post1 0, post2 0. The output is therefore +63 when the main-cursor bit is 1 and -63 when it is 0.
- R3: out_code = Cpre·s(x[n]) + Cmain·s(x[n-1]) + Cpost1·s(x[n-2]) + Cpost2·s(x[n-3]). Here s(1)=+1 and s(0)=-1, and x[n] is the bit accepted in the current valid cycle. The output is a signed 8-bit two's-complement code.
- R4: The result appears one clock after the valid input cycle, with out_valid high. With an unbroken stream, a bit's main-cursor contribution appears two clocks after that bit was presented.
- R5: When in_valid is 0, the history does not move. out_valid is 0 one clock later, and out_code keeps its last value. A stream with gaps gives the same code sequence as the same bits sent without gaps.
- R6: coef_in packs four 7-bit two's-complement weights: pre at bits [6:0], main at [13:7], post1 at [20:14] and post2 at [27:21]. A legal set presented with coef_load in a cycle becomes active for valid inputs from the next cycle on, and cfg_error is 0 from then on.
- R7: A set whose weight magnitudes do not sum to exactly 63 is rejected. cfg_error is 1 from the next cycle, and the previous active set stays in use.
- R8: A set with a positive pre-cursor weight or a positive post1 weight is rejected in the same way. Negative main weights and positive post2 weights are allowed.
- R9: cfg_error and the active weights change only in a cycle with coef_load high. cfg_error holds the result of the most recent load.
- R10: |out_code| never exceeds 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | in_bit carries a unit interval this cycle |
| in_bit | input | 1 | NRZ data bit |
| coef_load | input | 1 | Strobe that checks coef_in and latches it if legal |
| coef_in | input | 28 | Candidate weights, four 7-bit signed fields |
| out_valid | output | 1 | out_code holds a new result |
| out_code | output | 8 | Signed amplitude code |
| cfg_error | output | 1 | The most recent load was rejected |

## Verification
Three patterns run through the filter, and each isolates a different part of it. An all-ones run gives the low-frequency level of a weight set, which is the signed sum of its weights. An alternating pattern gives the peak emphasised level. A lone pulse in a field of zeros walks one +1 through each tap in turn, so it shows each weight on its own and exposes any swapped tap order or misaligned latency. Gapped streams must reproduce the same codes as unbroken ones. Rejected sets are probed by streaming afterwards and confirming that the old levels return.

// File: rtl/tx_fir_eq_pkg.sv
package tx_fir_eq_pkg;
    localparam int NTAPS      = 4;
    localparam int COEF_W     = 7;
    localparam int FULL_SCALE = 63;
    localparam int OUT_W      = 8;
    localparam int HIST_D     = NTAPS - 1;
    localparam int SUM_W      = COEF_W + $clog2(NTAPS) + 1;
    localparam int PRE_IDX    = 0;
    localparam int MAIN_IDX   = 1;
    localparam int POST1_IDX  = 2;
    localparam int POST2_IDX  = 3;
    // taps whose weight must be zero or negative
    localparam logic [NTAPS-1:0] NONPOS_MASK = (NTAPS)'((1 << PRE_IDX) | (1 << POST1_IDX));

    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic [NTAPS-1:0][COEF_W-1:0] coef_set_t;

    function automatic logic [SUM_W-1:0] coef_mag(input logic [COEF_W-1:0] c);
        logic [SUM_W-1:0] ext;
        ext = SUM_W'($signed(c));
        return c[COEF_W-1] ? (~ext + 1'b1) : ext;
    endfunction

    function automatic logic set_is_legal(input coef_set_t cs);
        logic [SUM_W-1:0] total;
        logic             ok;
        total = '0;
        ok    = 1'b1;
        for (int k = 0; k < NTAPS; k++) begin
            total = total + coef_mag(cs[k]);
            if (NONPOS_MASK[k] && !(cs[k][COEF_W-1] || cs[k] == '0))
                ok = 1'b0;
        end
        return ok && (total == SUM_W'(FULL_SCALE));
    endfunction

    function automatic coef_set_t reset_coefs();
        coef_set_t cs;
        cs = '0;
        cs[MAIN_IDX] = COEF_W'(FULL_SCALE);
        return cs;
    endfunction
endpackage

// File: rtl/fir_coef_guard.sv
module fir_coef_guard
    import tx_fir_eq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  coef_set_t cand,
    output coef_set_t active,
    output logic      cfg_error
);
    typedef struct packed {
        coef_set_t coef;
        logic      err;
    } guard_st_t;

    guard_st_t st_d, st_q;
    logic      cand_legal;

    always_comb begin
        cand_legal = set_is_legal(cand);
        st_d = st_q;
        if (load) begin
            st_d.err = !cand_legal;
            if (cand_legal)
                st_d.coef = cand;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.coef <= reset_coefs();
            st_q.err  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active    = st_q.coef;
    assign cfg_error = st_q.err;

    a_r9_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(active) && $stable(cfg_error)));
    a_r7_r8_active_set_legal: assert property (@(posedge clk) disable iff (!rst_n)
        set_is_legal(active));
    a_r7_reject_keeps_set: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !set_is_legal(cand)) |=> (cfg_error && $stable(active)));
    a_r6_accept_loads_set: assert property (@(posedge clk) disable iff (!rst_n)
        (load && set_is_legal(cand)) |=> (!cfg_error && active == $past(cand)));
endmodule

// File: rtl/fir_bit_history.sv
module fir_bit_history
    import tx_fir_eq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              bit_in,
    output logic [HIST_D-1:0] hist
);
    typedef struct packed {
        logic [HIST_D-1:0] taps;
    } hist_st_t;

    hist_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (valid) begin
            st_d.taps[0] = bit_in;
            for (int k = 1; k < HIST_D; k++)
                st_d.taps[k] = st_q.taps[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hist = st_q.taps;

    a_r5_history_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(hist));
    a_r3_newest_bit_enters: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> (hist[0] == $past(bit_in)));
endmodule

// File: rtl/fir_tap_sum.sv
module fir_tap_sum
    import tx_fir_eq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    valid,
    input  logic                    bit_now,
    input  logic [HIST_D-1:0]       hist,
    input  coef_set_t               coef,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_code
);
    typedef struct packed {
        logic                    vld;
        logic signed [OUT_W-1:0] code;
    } sum_st_t;

    sum_st_t st_d, st_q;
    logic [NTAPS-1:0]                   window;
    logic signed [NTAPS-1:0][SUM_W-1:0] term;
    logic signed [SUM_W-1:0]            acc;

    assign window[0] = bit_now;

    genvar g;
    generate
        for (g = 1; g < NTAPS; g++) begin : g_win
            assign window[g] = hist[g-1];
        end
        for (g = 0; g < NTAPS; g++) begin : g_term
            logic signed [SUM_W-1:0] wext;
            assign wext    = SUM_W'($signed(coef[g]));
            assign term[g] = window[g] ? wext : -wext;
        end
    endgenerate

    always_comb begin
        acc = '0;
        for (int k = 0; k < NTAPS; k++)
            acc = acc + term[k];
        st_d     = st_q;
        st_d.vld = valid;
        if (valid)
            st_d.code = OUT_W'(acc);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_code  = st_q.code;

    a_r4_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> out_valid);
    a_r5_gap_holds_code: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> (!out_valid && $stable(out_code)));
    a_r10_code_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (out_code <= OUT_W'(FULL_SCALE)) && (out_code >= -OUT_W'(FULL_SCALE)));
endmodule

// File: rtl/tx_fir_eq.sv
module tx_fir_eq
    import tx_fir_eq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_bit,
    input  logic                    coef_load,
    input  logic [NTAPS*COEF_W-1:0] coef_in,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_code,
    output logic                    cfg_error
);
    coef_set_t         cand_set;
    coef_set_t         active_set;
    logic [HIST_D-1:0] hist;

    assign cand_set = coef_set_t'(coef_in);

    fir_coef_guard u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (coef_load),
        .cand      (cand_set),
        .active    (active_set),
        .cfg_error (cfg_error)
    );

    fir_bit_history u_hist (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid  (in_valid),
        .bit_in (in_bit),
        .hist   (hist)
    );

    fir_tap_sum u_sum (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (in_valid),
        .bit_now   (in_bit),
        .hist      (hist),
        .coef      (active_set),
        .out_valid (out_valid),
        .out_code  (out_code)
    );
endmodule

// File: tb/tx_fir_eq_bench.sv
module tx_fir_eq_bench;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_bit = 1'b0;
    logic              coef_load = 1'b0;
    logic [27:0]       coef_in = '0;
    logic              out_valid;
    logic signed [7:0] out_code;
    logic              cfg_error;

    int n_checks = 0;
    int n_errors = 0;
    int m_c [4];
    int m_h [3];
    int m_code = 0;
    int m_err = 0;

    always #5 clk = ~clk;

    tx_fir_eq u_tx_fir_eq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
        .coef_load(coef_load), .coef_in(coef_in),
        .out_valid(out_valid), .out_code(out_code), .cfg_error(cfg_error)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int sgn(input int b);
        return b != 0 ? 1 : -1;
    endfunction

    function automatic logic [27:0] pack(input int c0, input int c1, input int c2, input int c3);
        logic [6:0] a, b, c, d;
        a = 7'(c0); b = 7'(c1); c = 7'(c2); d = 7'(c3);
        return {d, c, b, a};
    endfunction

    function automatic int legal(input int c0, input int c1, input int c2, input int c3);
        int s;
        s = (c0 < 0 ? -c0 : c0) + (c1 < 0 ? -c1 : c1) + (c2 < 0 ? -c2 : c2) + (c3 < 0 ? -c3 : c3);
        return (s == 63 && c0 <= 0 && c2 <= 0) ? 1 : 0;
    endfunction

    // called at a falling edge; drives one cycle and checks the registered result
    task automatic step(input string tag, input int v, input int b);
        in_valid = v[0];
        in_bit   = b[0];
        if (v != 0) begin
            m_code = m_c[0]*sgn(b) + m_c[1]*sgn(m_h[0]) + m_c[2]*sgn(m_h[1]) + m_c[3]*sgn(m_h[2]);
            m_h[2] = m_h[1]; m_h[1] = m_h[0]; m_h[0] = b;
        end
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " out_valid"}, int'(out_valid), v);
        check({tag, " out_code"}, int'(out_code), m_code);
        check("R10 range", int'((out_code <= 63 && out_code >= -63)), 1);
    endtask

    task automatic load(input string tag, input int c0, input int c1, input int c2, input int c3);
        coef_load = 1'b1;
        coef_in   = pack(c0, c1, c2, c3);
        @(negedge clk);
        coef_load = 1'b0;
        coef_in   = pack(5, 5, 5, 5);
        m_err = legal(c0, c1, c2, c3) != 0 ? 0 : 1;
        if (m_err == 0) begin
            m_c[0] = c0; m_c[1] = c1; m_c[2] = c2; m_c[3] = c3;
        end
        check({tag, " cfg_error"}, int'(cfg_error), m_err);
        check({tag, " no output on load"}, int'(out_valid), 0);
        @(negedge clk);
        check("R9 cfg_error held", int'(cfg_error), m_err);
    endtask

    task automatic t_reset;
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 out_code", int'(out_code), 0);
        check("R1 cfg_error", int'(cfg_error), 0);
    endtask

    task automatic t_passthrough;
        // first output: main cursor is reset history bit 0 -> -63
        step("R1 R2 first", 1, 1);
        check("R2 first level", m_code, -63);
        step("R2 pass", 1, 0);
        step("R2 pass", 1, 1);
        step("R2 pass", 1, 1);
        step("R2 pass", 1, 0);
        step("R4 latency", 1, 0);
    endtask

    task automatic t_patterns;
        load("R6 legal", -8, 47, -6, -2);
        for (int i = 0; i < 5; i++) step("R3 all ones", 1, 1);
        check("R3 dc level", int'(out_code), 31);
        for (int i = 0; i < 6; i++) step("R3 alternating", 1, i % 2);
        for (int i = 0; i < 4; i++) step("R3 zeros", 1, 0);
        step("R3 pulse pre", 1, 1);
        step("R3 pulse main", 1, 0);
        step("R3 pulse post1", 1, 0);
        step("R3 pulse post2", 1, 0);
        step("R3 pulse gone", 1, 0);
    endtask

    task automatic t_gaps;
        step("R5 gap", 1, 1);
        step("R5 gap", 0, 0);
        step("R5 gap", 0, 1);
        step("R5 gap", 1, 0);
        step("R5 gap", 0, 1);
        step("R5 gap", 1, 1);
        step("R5 gap", 1, 0);
    endtask

    task automatic t_illegal;
        load("R7 sum 56", -8, 40, -6, -2);
        for (int i = 0; i < 4; i++) step("R7 old set kept", 1, i % 2);
        load("R8 pre positive", 8, 47, -6, -2);
        step("R8 old set kept", 1, 1);
        load("R8 post1 positive", -8, 47, 6, -2);
        step("R8 old set kept", 1, 0);
        step("R8 old set kept", 1, 1);
        load("R7 sum 64", -1, 63, 0, 0);
        step("R7 old set kept", 1, 0);
    endtask

    task automatic t_boundary;
        load("R8 post2 positive ok", -4, 50, -6, 3);
        for (int i = 0; i < 5; i++) step("R3 post2 positive", 1, (i == 1) ? 1 : 0);
        load("R6 pre at -32", -32, 31, 0, 0);
        step("R10 extreme", 1, 0);
        step("R10 extreme", 1, 1);
        step("R10 extreme", 1, 0);
        load("R8 main negative ok", 0, -63, 0, 0);
        step("R6 inverted", 1, 1);
        step("R6 inverted", 1, 0);
        step("R6 inverted", 1, 0);
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        m_c[0] = 0; m_c[1] = 63; m_c[2] = 0; m_c[3] = 0;
        m_h[0] = 0; m_h[1] = 0; m_h[2] = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_passthrough();
        t_patterns();
        t_gaps();
        t_illegal();
        t_boundary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule